// File: doc/BRIEF.md
# Ring Interrupt Status Controller

This block gathers completion events from a set of transmit rings and receive rings, and overflow events from the receive rings, into sticky status bits. It drives one level interrupt per ring. Software reaches it through a simple 32-bit register port. Through that port software enables rings, reads status words that clear themselves on read, and clears enables or status by writing ones.

Each ring has an interrupt index. A transmit ring on hop `h` uses index `h`. A receive ring on hop `h` uses index `HOP_COUNT + h`. The status area is one long bit string holding three fields of `HOP_COUNT` bits each: transmit first, then receive, then receive-overflow. A field can therefore start partway into a 32-bit word.

A mode bit selects auto-clear operation. In auto-clear mode the write-one clear registers have no effect. Software then disables a ring by rewriting its enable word, and it clears status only by reading.

Top module: `isc_ring_irq_ctrl`

## Requirements
- R1: After reset, all enable bits, all status bits and the mode bit are 0, and every `ring_irq` bit is low.
- R2: The word at byte address 0x000 is read-only. It returns `HOP_COUNT` in bits [9:0] and zeros in all other bits. Writes to it have no effect.
- R3: Enable words sit at 0x100 + 4*(idx/32), with bit idx%32, for ring index idx (transmit hop h gives h, receive hop h gives HOP_COUNT+h). Enable bits at or above 2*HOP_COUNT read as 0. `ring_irq[idx]` is high exactly while both status bit idx and enable bit idx are set.
- R4: A transmit event on hop h sets status position h. A receive event sets position HOP_COUNT+h. An overflow event sets position 2*HOP_COUNT+h. Position p is read at notify word 0x180 + 4*(p/32), bit p%32. Status bits are sticky.
- R5: A read appears on `reg_rdata` one cycle after `reg_rd`. A read of a notify word returns its value and clears those status bits. An event arriving in the same cycle as that read stays set.
- R6: A write to the mask-clear word at 0x140 + 4*k clears each enable bit of word k whose written bit is 1. This holds only when the mode bit is 0. When the mode bit is 1, such writes have no effect.
- R7: A write to the clear word at 0x1C0 + 4*k clears each status bit of notify word k whose written bit is 1. This holds only when the mode bit is 0, and an event arriving in the same cycle wins. When the mode bit is 1, such writes have no effect.
- R8: Bit 0 of the word at 0x004 is the auto-clear mode bit. It is writable and reads back.
- R9: Writing an enable word sets every enable bit in it to the written value, in either mode, so rewriting the word without a ring's bit drops that ring's interrupt.
- R10: Overflow status bits never drive any `ring_irq` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | HOP_COUNT | Transmit ring completion event, one per hop |
| rx_evt | input | HOP_COUNT | Receive ring completion event, one per hop |
| ovf_evt | input | HOP_COUNT | Receive overflow event, one per hop |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ring_irq | output | 2*HOP_COUNT | Level interrupt per ring index |

## Verification
On every cycle, the assertions check four things. No event is lost to a concurrent clear. A mask-clear removes the interrupt of each masked ring. A clear write empties the bits it targets. A mask-clear in auto-clear mode leaves the enables untouched. They also check the capability value on each read of it. Some behaviours only the bench scenarios can show. These are the exact index and word mapping of every status position, the clear-on-read sequence with its one-cycle read latency, and the overflow field staying off the interrupt outputs. The bench covers them by sweeping every status position of a twelve-hop configuration whose overflow field crosses a word boundary.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned WIDX_W = 4;   // 16 words per region

  localparam logic [2:0] RGN_MISC = 3'b000;
  localparam logic [2:0] RGN_EN   = 3'b100;
  localparam logic [2:0] RGN_MCLR = 3'b101;
  localparam logic [2:0] RGN_NTFY = 3'b110;
  localparam logic [2:0] RGN_CLR  = 3'b111;

  typedef struct packed {
    logic              cap_sel;
    logic              ctrl_sel;
    logic              ctrl_wr;
    logic              en_wr;
    logic              en_sel;
    logic              mclr_wr;
    logic              ntfy_sel;
    logic              ntfy_rd;
    logic              clr_wr;
    logic [WIDX_W-1:0] word;
  } dec_t;

  function automatic int unsigned ring_index(input logic is_rx,
                                             input int unsigned hop,
                                             input int unsigned hop_cnt);
    return is_rx ? hop + hop_cnt : hop;
  endfunction

  function automatic int unsigned word_of(input int unsigned idx);
    return idx / REG_W;
  endfunction

  function automatic int unsigned pos_of(input int unsigned idx);
    return idx % REG_W;
  endfunction

  function automatic int unsigned words_for(input int unsigned nbits);
    return (nbits + REG_W - 1) / REG_W;
  endfunction
endpackage

// File: rtl/isc_addr_dec.sv
module isc_addr_dec
  import isc_pkg::*;
(
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [2:0] rgn;
  logic       aligned;

  assign rgn     = addr[ADDR_W-1 -: 3];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec          = '0;
    dec.word     = addr[2 +: WIDX_W];
    if (aligned) begin
      dec.cap_sel  = (rgn == RGN_MISC) && (dec.word == WIDX_W'(0));
      dec.ctrl_sel = (rgn == RGN_MISC) && (dec.word == WIDX_W'(1));
      dec.ctrl_wr  = dec.ctrl_sel && wr;
      dec.en_sel   = (rgn == RGN_EN);
      dec.en_wr    = dec.en_sel && wr;
      dec.mclr_wr  = (rgn == RGN_MCLR) && wr;
      dec.ntfy_sel = (rgn == RGN_NTFY);
      dec.ntfy_rd  = dec.ntfy_sel && rd;
      dec.clr_wr   = (rgn == RGN_CLR) && wr;
    end
  end
endmodule

// File: rtl/isc_enable_bank.sv
module isc_enable_bank
  import isc_pkg::*;
#(
  parameter int unsigned NB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              mclr_wr,
  input  logic              auto_mode,
  input  logic [WIDX_W-1:0] word,
  input  logic [REG_W-1:0]  wdata,
  output logic [NB-1:0]     en_q,
  output logic [NB-1:0]     mclr_vec
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    localparam int unsigned W = word_of(b);
    localparam int unsigned P = pos_of(b);
    logic hit;
    logic en_r;
    assign hit         = (word == WIDX_W'(W));
    assign mclr_vec[b] = mclr_wr && !auto_mode && hit && wdata[P];
    always_ff @(posedge clk) begin
      if (!rst_n)             en_r <= 1'b0;
      else if (en_wr && hit)  en_r <= wdata[P];
      else if (mclr_vec[b])   en_r <= 1'b0;
    end
    assign en_q[b] = en_r;
  end
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank
  import isc_pkg::*;
#(
  parameter int unsigned NB = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     set_vec,
  input  logic              ntfy_rd,
  input  logic              clr_wr,
  input  logic              auto_mode,
  input  logic [WIDX_W-1:0] word,
  input  logic [REG_W-1:0]  wdata,
  output logic [NB-1:0]     sts_q,
  output logic [NB-1:0]     clr_vec
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    localparam int unsigned W = word_of(b);
    localparam int unsigned P = pos_of(b);
    logic hit;
    logic sts_r;
    assign hit        = (word == WIDX_W'(W));
    assign clr_vec[b] = (ntfy_rd && hit) ||
                        (clr_wr && !auto_mode && hit && wdata[P]);
    // a new event outranks any clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n) sts_r <= 1'b0;
      else        sts_r <= set_vec[b] | (sts_r & ~clr_vec[b]);
    end
    assign sts_q[b] = sts_r;
  end
endmodule

// File: rtl/isc_ring_irq_ctrl.sv
module isc_ring_irq_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned HOP_COUNT = 12   // at most 170: notify area fits 16 words
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HOP_COUNT-1:0]   tx_evt,
  input  logic [HOP_COUNT-1:0]   rx_evt,
  input  logic [HOP_COUNT-1:0]   ovf_evt,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic [2*HOP_COUNT-1:0] ring_irq
);
  localparam int unsigned NR = 2 * HOP_COUNT;
  localparam int unsigned NS = 3 * HOP_COUNT;
  localparam int unsigned EW = words_for(NR);
  localparam int unsigned NW = words_for(NS);

  dec_t              dec;
  logic              auto_q;
  logic [NR-1:0]     en_q;
  logic [NR-1:0]     mclr_vec;
  logic [NS-1:0]     sts_q;
  logic [NS-1:0]     clr_vec;
  logic [NS-1:0]     set_vec;
  logic [EW*REG_W-1:0] en_pad;
  logic [NW*REG_W-1:0] nt_pad;
  logic [REG_W-1:0]  rd_word;
  logic [REG_W-1:0]  rdata_q;

  // named events for the checker
  logic cap_rd;
  logic en_req;
  logic mclr_req;

  assign set_vec  = {ovf_evt, rx_evt, tx_evt};
  assign cap_rd   = dec.cap_sel && reg_rd;
  assign en_req   = dec.en_wr;
  assign mclr_req = dec.mclr_wr;

  isc_addr_dec u_dec (
    .wr   (reg_wr),
    .rd   (reg_rd),
    .addr (reg_addr),
    .dec  (dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           auto_q <= 1'b0;
    else if (dec.ctrl_wr) auto_q <= reg_wdata[0];
  end

  isc_enable_bank #(.NB(NR)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (dec.en_wr),
    .mclr_wr   (dec.mclr_wr),
    .auto_mode (auto_q),
    .word      (dec.word),
    .wdata     (reg_wdata),
    .en_q      (en_q),
    .mclr_vec  (mclr_vec)
  );

  isc_status_bank #(.NB(NS)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .ntfy_rd   (dec.ntfy_rd),
    .clr_wr    (dec.clr_wr),
    .auto_mode (auto_q),
    .word      (dec.word),
    .wdata     (reg_wdata),
    .sts_q     (sts_q),
    .clr_vec   (clr_vec)
  );

  assign en_pad = (EW*REG_W)'(en_q);
  assign nt_pad = (NW*REG_W)'(sts_q);

  always_comb begin
    rd_word = '0;
    if (dec.cap_sel)  rd_word = REG_W'(10'(HOP_COUNT));
    if (dec.ctrl_sel) rd_word = REG_W'(auto_q);
    for (int w = 0; w < int'(EW); w++)
      if (dec.en_sel && dec.word == WIDX_W'(w)) rd_word = en_pad[w*REG_W +: REG_W];
    for (int w = 0; w < int'(NW); w++)
      if (dec.ntfy_sel && dec.word == WIDX_W'(w)) rd_word = nt_pad[w*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_word;
  end

  assign reg_rdata = rdata_q;
  assign ring_irq  = sts_q[NR-1:0] & en_q;
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int unsigned HOP_COUNT = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   auto_q,
  input logic                   cap_rd,
  input logic                   en_req,
  input logic                   mclr_req,
  input logic [2*HOP_COUNT-1:0] en_q,
  input logic [2*HOP_COUNT-1:0] mclr_vec,
  input logic [3*HOP_COUNT-1:0] sts_q,
  input logic [3*HOP_COUNT-1:0] set_vec,
  input logic [3*HOP_COUNT-1:0] clr_vec,
  input logic [2*HOP_COUNT-1:0] ring_irq,
  input logic [31:0]            reg_rdata
);
  a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  a_r6_mask_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_vec != '0) |=> ((ring_irq & $past(mclr_vec)) == '0));

  a_r6_auto_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && mclr_req && !en_req) |=> $stable(en_q));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((sts_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  a_r2_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd |=> (reg_rdata == 32'(HOP_COUNT)));
endmodule

bind isc_ring_irq_ctrl isc_checker #(.HOP_COUNT(HOP_COUNT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .auto_q    (auto_q),
  .cap_rd    (cap_rd),
  .en_req    (en_req),
  .mclr_req  (mclr_req),
  .en_q      (en_q),
  .mclr_vec  (mclr_vec),
  .sts_q     (sts_q),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .ring_irq  (ring_irq),
  .reg_rdata (reg_rdata)
);

// File: tb/isc_ring_irq_ctrl_tb.sv
module isc_ring_irq_ctrl_tb_top;
  localparam int H  = 12;
  localparam int NR = 2 * H;
  localparam int NS = 3 * H;
  localparam logic [8:0] A_CAP = 9'h000, A_CTRL = 9'h004, A_EN = 9'h100,
                         A_MCLR = 9'h140, A_NTFY = 9'h180, A_CLR = 9'h1C0;

  logic clk = 0;
  logic rst_n = 0;
  logic [H-1:0] tx_evt = '0, rx_evt = '0, ovf_evt = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NR-1:0] ring_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  isc_ring_irq_ctrl #(.HOP_COUNT(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .ovf_evt(ovf_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ring_irq(ring_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // drive the event that lands on status position p
  task automatic set_evt(input int p);
    if (p < H)        tx_evt[p] = 1'b1;
    else if (p < NR)  rx_evt[p - H] = 1'b1;
    else              ovf_evt[p - NR] = 1'b1;
  endtask

  task automatic drop_evt();
    tx_evt = '0; rx_evt = '0; ovf_evt = '0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk); set_evt(p);
    @(negedge clk); drop_evt();
  endtask

  function automatic logic [8:0] ntfy_addr(input int p);
    return A_NTFY + 9'((p >> 5) << 2);
  endfunction

  function automatic logic [31:0] onehot(input int p);
    return 32'h1 << (p & 31);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(ring_irq), 32'h0);
    rd(A_EN, d);         chk("R1 enable", d, 32'h0);
    rd(A_NTFY, d);       chk("R1 notify0", d, 32'h0);
    rd(A_NTFY + 4, d);   chk("R1 notify1", d, 32'h0);
    rd(A_CTRL, d);       chk("R1 ctrl", d, 32'h0);

    // R2 capability
    rd(A_CAP, d);        chk("R2 cap", d, 32'(H));
    wr(A_CAP, 32'hFFFF_FFFF);
    rd(A_CAP, d);        chk("R2 cap read-only", d, 32'(H));

    // R8 mode bit
    wr(A_CTRL, 32'h1);   rd(A_CTRL, d); chk("R8 ctrl set", d, 32'h1);
    wr(A_CTRL, 32'h0);   rd(A_CTRL, d); chk("R8 ctrl clear", d, 32'h0);

    // R3 enable word, bits past the ring count read zero
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d);         chk("R3 enable width", d, (32'h1 << NR) - 1);

    // R3 R4 R5 R10 sweep of every status position, clear by read
    for (int p = 0; p < NS; p++) begin
      pulse(p);
      chk("R3/R10 irq", 32'(ring_irq), (p < NR) ? (32'h1 << p) : 32'h0);
      rd(ntfy_addr(p), d); chk("R4 position", d, onehot(p));
      rd(ntfy_addr(p), d); chk("R5 clear on read", d, 32'h0);
      chk("R5 irq gone", 32'(ring_irq), 32'h0);
    end

    // R7 sweep: clear register, non-auto mode
    for (int p = 0; p < NS; p++) begin
      pulse(p);
      wr(A_CLR + 9'((p >> 5) << 2), onehot(p));
      rd(ntfy_addr(p), d); chk("R7 clear write", d, 32'h0);
    end

    // R5 event during a notify read survives
    @(negedge clk); reg_rd = 1; reg_addr = A_NTFY; tx_evt[0] = 1'b1;
    @(negedge clk); reg_rd = 0; tx_evt = '0; d = reg_rdata;
    chk("R5 read during event", d, 32'h0);
    rd(A_NTFY, d);       chk("R5 event kept", d, 32'h1);

    // R7 event during a clear write wins
    @(negedge clk); reg_wr = 1; reg_addr = A_CLR; reg_wdata = 32'h2; tx_evt[1] = 1'b1;
    @(negedge clk); reg_wr = 0; tx_evt = '0;
    rd(A_NTFY, d);       chk("R7 event wins", d, 32'h2);

    // R6 mask-clear outside auto mode
    wr(A_MCLR, 32'h0000_00F0);
    rd(A_EN, d);         chk("R6 mask clear", d, 32'h00FF_FF0F);

    // auto-clear mode
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    pulse(3);
    chk("R3 irq auto", 32'(ring_irq), 32'h8);
    wr(A_EN, 32'h00FF_FFF7);
    chk("R9 rewrite disables", 32'(ring_irq), 32'h0);
    wr(A_MCLR, 32'hFFFF_FFFF);
    rd(A_EN, d);         chk("R6 mask ignored auto", d, 32'h00FF_FFF7);
    pulse(H);            // rx hop 0 -> position 12
    chk("R3 rx irq", 32'(ring_irq), 32'h1000);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_NTFY, d);       chk("R7 clear ignored auto", d, 32'h0000_1008);
    rd(A_NTFY, d);       chk("R5 auto read clears", d, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule